// File: doc/BRIEF.md
# UART Interrupt Status Controller

This block merges the interrupt requests of a UART into a single active-high interrupt line. It also builds the identification byte that the CPU reads to find out which source to service first. The receiver, line-status and modem-status logic sit next to it and each supply a level request that they clear themselves when their own register is read. The only request held inside this block is the one raised when the transmit holding register becomes empty. It is set on the empty edge and cleared either by writing the transmit register or by reading the identification byte while that byte names the transmit source.

The CPU reads the identification byte after an interrupt. Only sources enabled in the interrupt-enable bits are reported. When several are pending, the one with the highest priority is reported. A receive timeout counts only while the FIFOs are enabled. A modem status change counts only while automatic clear-to-send flow control is off.

Top module: `uart_irq_ctrl`

## Requirements
- R1: `irq_o` is 1 exactly when at least one enabled, qualified source is pending. The enable bits are `ier_i[0]` for receive data and timeout, `ier_i[1]` for transmit empty, `ier_i[2]` for line error and `ier_i[3]` for modem change. `irq_o` is 1 exactly when `iir_o[3:0]` differs from 0x1.
- R2: Priority runs from highest to lowest as follows: line error, then receive timeout, then receive data, then transmit empty, then modem change.
- R3: `iir_o[3:0]` reports the highest-priority pending source with these codes: 0x1 none, 0x6 line error, 0xC receive timeout, 0x4 receive data, 0x2 transmit empty, 0x0 modem change.
- R4: `iir_o[7:6]` equals 2'b11 when `fifo_en_i` is 1 and 2'b00 otherwise. `iir_o[5:4]` is always 0.
- R5: `rx_tmo_i` has no effect while `fifo_en_i` is 0.
- R6: `ms_chg_i` has no effect while `auto_cts_i` is 1.
- R7: A rising edge of `thr_empty_i` sets the transmit-empty request. The request is visible on the outputs after the next clock edge.
- R8: A cycle with `iir_rd_i` high while `iir_o[3:0]` is 0x2 clears the transmit-empty request.
- R9: A cycle with `iir_rd_i` high while another code is reported leaves the transmit-empty request pending.
- R10: A cycle with `thr_wr_i` high clears the transmit-empty request.
- R11: While `rst_n` is low the transmit-empty request is clear. A `thr_empty_i` that is already high when reset is released raises no request until it has fallen and risen again.
- R12: A source whose enable bit is 0 is not reported, and the next enabled source below it is reported instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| line_err_i | input | 1 | Receiver line error pending (level) |
| rx_data_i | input | 1 | Receive data available (level) |
| rx_tmo_i | input | 1 | Receive timeout pending (level) |
| thr_empty_i | input | 1 | Transmit holding register empty (level) |
| ms_chg_i | input | 1 | Modem status change pending (level) |
| auto_cts_i | input | 1 | Automatic clear-to-send flow control active |
| fifo_en_i | input | 1 | FIFO mode enabled |
| ier_i | input | 4 | Interrupt enable bits |
| iir_rd_i | input | 1 | Identification register read strobe |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| irq_o | output | 1 | Interrupt, active high |
| iir_o | output | 8 | Interrupt identification byte |

## Verification
The bench sweeps every combination of the level sources, the enables, the FIFO flag and auto clear-to-send. It does this once with the transmit-empty request held and once with it clear. This exposes a swapped priority, which would report the wrong code whenever two sources overlap. It also exposes a timeout or modem request that leaks through its qualifier, which would raise an interrupt with nothing enabled to cause it. Directed sequences target the transmit-empty latch. An identification read made while a line error is reported must not drop it; a design that cleared on every read would lose the transmit interrupt there. A stale empty level after reset must not raise it, and a read or a write must clear it one cycle after the strobe.

// File: rtl/uart_irq_pkg.sv
`timescale 1ns/1ps
package uart_irq_pkg;

  localparam int unsigned IER_W   = 4;
  localparam int unsigned IIR_W   = 8;
  localparam int unsigned CODE_W  = 4;

  // enable bit positions
  localparam int unsigned EN_RX   = 0;
  localparam int unsigned EN_TX   = 1;
  localparam int unsigned EN_LINE = 2;
  localparam int unsigned EN_MS   = 3;

  typedef enum logic [CODE_W-1:0] {
    IC_MSC  = 4'h0,
    IC_NONE = 4'h1,
    IC_TXE  = 4'h2,
    IC_RXD  = 4'h4,
    IC_LINE = 4'h6,
    IC_RTO  = 4'hC
  } irq_code_e;

  typedef struct packed {
    logic line;
    logic rto;
    logic rxd;
    logic txe;
    logic msc;
  } irq_req_t;

endpackage

// File: rtl/uart_irq_txe.sv
`timescale 1ns/1ps
module uart_irq_txe (
  input  logic clk,
  input  logic rst_n,
  input  logic empty_i,
  input  logic wr_i,
  input  logic rd_clr_i,
  output logic pend_o
);

  logic empty_q, empty_d;
  logic pend_q, pend_d;
  logic rise;

  assign rise = empty_i & ~empty_q;

  always_comb begin
    empty_d = empty_i;
    pend_d  = pend_q;
    if (wr_i || rd_clr_i) pend_d = 1'b0;
    if (rise)             pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      pend_q  <= 1'b0;
    end else begin
      empty_q <= empty_d;
      pend_q  <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R7
  a_r7_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_i && !empty_q) |=> pend_q);
  // R10
  a_r10_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !(empty_i && !empty_q)) |=> !pend_q);
  // R8
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_i && !(empty_i && !empty_q)) |=> !pend_q);

endmodule

// File: rtl/uart_irq_prio.sv
`timescale 1ns/1ps
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  irq_req_t  req_i,
  output irq_code_e code_o
);

  always_comb begin
    if      (req_i.line) code_o = IC_LINE;
    else if (req_i.rto)  code_o = IC_RTO;
    else if (req_i.rxd)  code_o = IC_RXD;
    else if (req_i.txe)  code_o = IC_TXE;
    else if (req_i.msc)  code_o = IC_MSC;
    else                 code_o = IC_NONE;
  end

endmodule

// File: rtl/uart_irq_ctrl.sv
`timescale 1ns/1ps
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_err_i,
  input  logic             rx_data_i,
  input  logic             rx_tmo_i,
  input  logic             thr_empty_i,
  input  logic             ms_chg_i,
  input  logic             auto_cts_i,
  input  logic             fifo_en_i,
  input  logic [IER_W-1:0] ier_i,
  input  logic             iir_rd_i,
  input  logic             thr_wr_i,
  output logic             irq_o,
  output logic [IIR_W-1:0] iir_o
);

  localparam int unsigned PAD_W = IIR_W - CODE_W - 2;

  irq_req_t  req;
  irq_code_e code;
  logic      txe_pend;
  logic      rd_txe;

  assign rd_txe = iir_rd_i & (code == IC_TXE);

  uart_irq_txe u_txe (
    .clk      (clk),
    .rst_n    (rst_n),
    .empty_i  (thr_empty_i),
    .wr_i     (thr_wr_i),
    .rd_clr_i (rd_txe),
    .pend_o   (txe_pend)
  );

  always_comb begin
    req.line = line_err_i & ier_i[EN_LINE];
    req.rto  = rx_tmo_i   & fifo_en_i   & ier_i[EN_RX];
    req.rxd  = rx_data_i  & ier_i[EN_RX];
    req.txe  = txe_pend   & ier_i[EN_TX];
    req.msc  = ms_chg_i   & ~auto_cts_i & ier_i[EN_MS];
  end

  uart_irq_prio u_prio (
    .req_i  (req),
    .code_o (code)
  );

  assign irq_o = (code != IC_NONE);
  assign iir_o = {{2{fifo_en_i}}, {PAD_W{1'b0}}, code};

  // R1
  a_r1_irq_vs_code: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (iir_o[3:0] != 4'h1));
  // R2
  a_r2_line_first: assert property (@(posedge clk) disable iff (!rst_n)
    (line_err_i && ier_i[EN_LINE]) |-> (iir_o[3:0] == 4'h6));
  // R4
  a_r4_fifo_bits: assert property (@(posedge clk) disable iff (!rst_n)
    iir_o[7:4] == {fifo_en_i, fifo_en_i, 2'b00});
  // R5
  a_r5_no_tmo_code: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en_i |-> (iir_o[3:0] != 4'hC));
  // R6
  a_r6_no_msc_code: assert property (@(posedge clk) disable iff (!rst_n)
    auto_cts_i |-> (iir_o[3:0] != 4'h0));

endmodule

// File: tb/test_uart_irq_ctrl.sv
`timescale 1ns/1ps
module test_uart_irq_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       line_err, rx_data, rx_tmo, thr_empty, ms_chg, auto_cts, fifo_en;
  logic [3:0] ier;
  logic       iir_rd, thr_wr;
  logic       irq;
  logic [7:0] iir;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  uart_irq_ctrl i_uart_irq_ctrl (
    .clk(clk), .rst_n(rst_n),
    .line_err_i(line_err), .rx_data_i(rx_data), .rx_tmo_i(rx_tmo),
    .thr_empty_i(thr_empty), .ms_chg_i(ms_chg), .auto_cts_i(auto_cts),
    .fifo_en_i(fifo_en), .ier_i(ier), .iir_rd_i(iir_rd), .thr_wr_i(thr_wr),
    .irq_o(irq), .iir_o(iir)
  );

  function automatic logic [8:0] model(input logic le, rd, to, ms, ac, fe,
                                       input logic [3:0] en, input logic txp);
    logic [3:0] c;
    if      (en[2] && le)        c = 4'h6;
    else if (en[0] && to && fe)  c = 4'hC;
    else if (en[0] && rd)        c = 4'h4;
    else if (en[1] && txp)       c = 4'h2;
    else if (en[3] && ms && !ac) c = 4'h0;
    else                         c = 4'h1;
    return {c != 4'h1, fe, fe, 2'b00, c};
  endfunction

  task automatic check(input string req, input logic [8:0] exp);
    n_chk++;
    if ({irq, iir} !== exp) begin
      n_bad++;
      $display("FAIL %s: irq/iir got %b/%h expected %b/%h", req, irq, iir, exp[8], exp[7:0]);
    end
  endtask

  task automatic sweep(input logic txp);
    for (int v = 0; v < 1024; v++) begin
      @(negedge clk);
      {line_err, rx_data, rx_tmo, ms_chg, auto_cts, fifo_en, ier} = v[9:0];
      #2;
      // R1 R2 R3 R4 R5 R6 R12
      check("R1/R2/R3/R4/R5/R6/R12 sweep",
            model(line_err, rx_data, rx_tmo, ms_chg, auto_cts, fifo_en, ier, txp));
    end
  endtask

  task automatic quiet();
    {line_err, rx_data, rx_tmo, ms_chg, auto_cts, fifo_en} = '0;
  endtask

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    quiet();
    thr_empty = 1'b1; ier = 4'h2; iir_rd = 1'b0; thr_wr = 1'b0;
    #3;
    check("R11 in reset", 9'h001);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    check("R11 stale empty after reset", 9'h001);

    // R7 fresh edge
    @(negedge clk); thr_empty = 1'b0;
    @(negedge clk); thr_empty = 1'b1; #2;
    check("R7 before edge", 9'h001);
    @(negedge clk); #2;
    check("R7 after edge", 9'h102);

    ier = 4'hF;
    sweep(1'b1);
    quiet(); ier = 4'h2;

    // R9 read while line error reported
    line_err = 1'b1; ier = 4'h6;
    @(negedge clk); #2;
    check("R9 line reported", 9'h106);
    @(negedge clk); iir_rd = 1'b1;
    @(negedge clk); iir_rd = 1'b0; line_err = 1'b0; #2;
    check("R9 tx kept", 9'h102);

    // R8 read while tx reported
    @(negedge clk); iir_rd = 1'b1;
    @(negedge clk); iir_rd = 1'b0; #2;
    check("R8 read clears", 9'h001);

    sweep(1'b0);
    quiet(); ier = 4'h2;

    // R10 write clears
    @(negedge clk); thr_empty = 1'b0;
    @(negedge clk); thr_empty = 1'b1;
    @(negedge clk); #2;
    check("R10 pending before write", 9'h102);
    thr_wr = 1'b1; thr_empty = 1'b0;
    @(negedge clk); thr_wr = 1'b0; #2;
    check("R10 write clears", 9'h001);

    // R12 disabled tx not reported, modem reported below it
    @(negedge clk); thr_empty = 1'b1;
    @(negedge clk); ms_chg = 1'b1; ier = 4'h8; #2;
    check("R12 tx disabled, modem shown", 9'h100);
    ier = 4'hA; #1;
    check("R2 tx above modem", 9'h102);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule